// File: doc/BRIEF.md
# PRBS/QRSS Pattern Sync Monitor

This block watches a received serial bit stream and decides whether it carries the pseudo-random test pattern of the selected line type. On an E1 line it checks a 15-stage maximal-length sequence. On a T1/J1 line it checks a 20-stage quasi-random sequence with zero suppression. While out of sync it loads its reference shift register straight from the incoming bits, so no seed has to be supplied. It declares sync once a run of predicted bits matches the stream. Once in sync the reference runs free. Each received bit that disagrees with it is flagged, and sync is given up when errors pile up faster than about one in a hundred bits.

Bits arrive as beats on a valid/ready stream, one bit per beat, where a beat is a cycle with `bit_valid_i` and `bit_ready_o` both high. The monitor never applies back-pressure: `bit_ready_o` goes high on the first clock edge after reset is released and stays high. A sender therefore never has to hold a bit. A cycle without valid is a gap, and gaps do not advance the monitor. The line type pin and the two status outputs are plain signals.

Top module: `prbs_sync_mon`

## Requirements
- R1: While reset is active, `sync_o`, `err_o` and `bit_ready_o` are 0. `bit_ready_o` becomes 1 at the first edge after release and stays 1 with no back-pressure.
- R2: With `line_mode_i` = 0 (E1), each reference bit is b[n] = b[n-15] XOR b[n-14].
- R3: Out of sync, every beat shifts the received bit into the reference. `sync_o` rises the cycle after the 32nd consecutive beat whose bit equals the prediction.
- R4: With `line_mode_i` = 1 (T1/J1), the raw reference bit is r[n] = r[n-20] XOR r[n-17]. The predicted bit is forced to 1 whenever the previous 14 raw bits are all 0.
- R5: A beat never counts as a match while the reference bits used by the current mode are all 0, so an all-zero stream never gives sync.
- R6: In sync, the reference advances from its own feedback and not from the received bit. `err_o` is high for exactly the one cycle after each beat that mismatches, and is never high after a beat compared out of sync.
- R7: From sync acquisition, beats are counted in consecutive blocks of 1000. Up to 10 errors in a block keep sync. The 11th error in a block clears `sync_o` the cycle after that beat. The error count restarts at each block boundary.
- R8: When `line_mode_i` differs from its value at the previous edge, the monitor is out of sync after the next edge and its match run is cleared. A beat in that cycle only seeds the reference.
- R9: A cycle without a beat changes neither `sync_o` nor the reference, and leaves `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_mode_i | input | 1 | Pattern select: 0 E1 15-stage, 1 T1/J1 20-stage quasi-random |
| bit_valid_i | input | 1 | Received bit is present this cycle |
| bit_data_i | input | 1 | Received bit |
| bit_ready_o | output | 1 | Monitor accepts a bit (high from the first edge after reset) |
| sync_o | output | 1 | Pattern sync status level |
| err_o | output | 1 | One-cycle pulse for each bit in error while in sync |

## Verification
The bench starts the T1/J1 stream just before the longest raw zero run. This puts forced ones into a synced stretch, so a monitor that forces on the wrong run length, or that forces into its feedback, raises false error pulses there. Error bursts are placed exactly on a block boundary: ten errors must leave sync alone, and the eleventh must drop it on that beat. An off-by-one threshold or a window that does not restart on acquisition shifts or hides the drop. An all-zero E1 stream checks the lock-up guard, without which the monitor would declare sync on a dead line. Mode flips and random valid gaps check that a monitor which keeps sync across a pattern change, or advances on idle cycles, is caught.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  typedef enum logic {
    LINE_E1 = 1'b0,
    LINE_T1 = 1'b1
  } line_mode_e;

  // E1 pattern: x^15 + x^14 + 1
  localparam int unsigned E1_STAGES = 15;
  localparam int unsigned E1_TAP    = 14;
  // T1/J1 pattern: x^20 + x^17 + 1 with zero suppression
  localparam int unsigned T1_STAGES = 20;
  localparam int unsigned T1_TAP    = 17;
  localparam int unsigned T1_ZRUN   = 14;

  localparam int unsigned LOCK_RUN  = 32;
  localparam int unsigned BLOCK_LEN = 1000;
  localparam int unsigned ERR_MAX   = 10;

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_mon_pkg::*;
#(
  parameter int unsigned E1_LEN = E1_STAGES,
  parameter int unsigned E1_TP  = E1_TAP,
  parameter int unsigned T1_LEN = T1_STAGES,
  parameter int unsigned T1_TP  = T1_TAP,
  parameter int unsigned ZRUN   = T1_ZRUN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_mode_e mode,
  input  logic       shift_en,
  input  logic       load_rx,
  input  logic       rx_bit,
  output logic       pred_bit,
  output logic       seeded
);

  localparam int unsigned W = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;

  logic [W-1:0] hist_q;
  logic         fb_e1, fb_t1, zfill_t1, live_e1, live_t1;
  logic         fb_sel;

  assign fb_e1   = hist_q[E1_LEN-1] ^ hist_q[E1_TP-1];
  assign fb_t1   = hist_q[T1_LEN-1] ^ hist_q[T1_TP-1];
  assign live_e1 = |hist_q[E1_LEN-1:0];
  assign live_t1 = |hist_q[T1_LEN-1:0];

  generate
    if (ZRUN > 0) begin : g_zsup
      assign zfill_t1 = ~|hist_q[ZRUN-1:0];
    end else begin : g_no_zsup
      assign zfill_t1 = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      LINE_E1: begin
        fb_sel   = fb_e1;
        pred_bit = fb_e1;
        seeded   = live_e1;
      end
      default: begin
        fb_sel   = fb_t1;
        pred_bit = fb_t1 | zfill_t1;
        seeded   = live_t1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[W-2:0], load_rx ? rx_bit : fb_sel};
    end
  end

  // Free-running reference in sync: newest stage follows feedback, not data
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_rx && (rx_bit != pred_bit) && !(mode == LINE_T1 && zfill_t1))
      |=> (hist_q[0] != $past(rx_bit))); // R6

endmodule

// File: rtl/prbs_acq_ctrl.sv
module prbs_acq_ctrl
  import prbs_mon_pkg::*;
#(
  parameter int unsigned SYNC_RUN = LOCK_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic mode_chg,
  input  logic hit,
  input  logic seeded,
  input  logic drop,
  output logic in_sync,
  output logic acquire
);

  localparam int unsigned RW = $clog2(SYNC_RUN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(SYNC_RUN - 1);

  logic [RW-1:0] run_q;
  logic          sync_q;
  logic          good;

  assign good    = beat && !sync_q && !mode_chg && hit && seeded;
  assign acquire = good && (run_q == RUN_LAST);
  assign in_sync = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= '0;
    end else if (mode_chg) begin
      sync_q <= 1'b0;
      run_q  <= '0;
    end else if (beat) begin
      if (!sync_q) begin
        if (acquire) begin
          sync_q <= 1'b1;
          run_q  <= '0;
        end else if (good) begin
          run_q  <= run_q + 1'b1;
        end else begin
          run_q  <= '0;
        end
      end else if (drop) begin
        sync_q <= 1'b0;
        run_q  <= '0;
      end
    end
  end

  AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> ($past(run_q) == RUN_LAST)); // R3

  AST_NO_LOCK_UNSEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sync_q && !seeded) |=> !sync_q); // R5

  AST_MODE_CHG_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !sync_q); // R8

endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window
  import prbs_mon_pkg::*;
#(
  parameter int unsigned WIN_LEN   = BLOCK_LEN,
  parameter int unsigned ERR_LIMIT = ERR_MAX
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic chk_beat,
  input  logic miss,
  output logic drop
);

  localparam int unsigned BW = $clog2(WIN_LEN);
  localparam int unsigned EW = $clog2(ERR_LIMIT + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WIN_LEN - 1);
  localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_LIMIT);

  logic [BW-1:0] bit_cnt_q;
  logic [EW-1:0] err_cnt_q;
  logic          blk_end;

  assign blk_end = (bit_cnt_q == BIT_LAST);
  assign drop    = chk_beat && miss && (err_cnt_q == ERR_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      err_cnt_q <= '0;
    end else if (clear || drop) begin
      bit_cnt_q <= '0;
      err_cnt_q <= '0;
    end else if (chk_beat) begin
      bit_cnt_q <= blk_end ? '0 : bit_cnt_q + 1'b1;
      err_cnt_q <= blk_end ? '0 : err_cnt_q + EW'(miss);
    end
  end

  AST_ERR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_q <= ERR_TOP); // R7

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= BIT_LAST); // R7

endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon
  import prbs_mon_pkg::*;
#(
  parameter int unsigned E1_LEN    = E1_STAGES,
  parameter int unsigned E1_TP     = E1_TAP,
  parameter int unsigned T1_LEN    = T1_STAGES,
  parameter int unsigned T1_TP     = T1_TAP,
  parameter int unsigned ZRUN      = T1_ZRUN,
  parameter int unsigned SYNC_RUN  = LOCK_RUN,
  parameter int unsigned WIN_LEN   = BLOCK_LEN,
  parameter int unsigned ERR_LIMIT = ERR_MAX
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_mode_i,
  input  logic bit_valid_i,
  input  logic bit_data_i,
  output logic bit_ready_o,
  output logic sync_o,
  output logic err_o
);

  line_mode_e mode_now, mode_q;
  logic       ready_q, err_q;
  logic       beat, mode_chg, pred, seeded, hit;
  logic       in_sync, acquire, drop, chk_beat;

  assign mode_now = line_mode_e'(line_mode_i);
  assign mode_chg = (mode_now != mode_q);
  assign beat     = bit_valid_i && ready_q;
  assign hit      = (bit_data_i == pred);
  assign chk_beat = beat && in_sync && !mode_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= LINE_E1;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_now;
      ready_q <= 1'b1;
      err_q   <= chk_beat && !hit;
    end
  end

  prbs_ref_gen #(
    .E1_LEN (E1_LEN),
    .E1_TP  (E1_TP),
    .T1_LEN (T1_LEN),
    .T1_TP  (T1_TP),
    .ZRUN   (ZRUN)
  ) i_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_now),
    .shift_en (beat),
    .load_rx  (!in_sync || mode_chg),
    .rx_bit   (bit_data_i),
    .pred_bit (pred),
    .seeded   (seeded)
  );

  prbs_acq_ctrl #(
    .SYNC_RUN (SYNC_RUN)
  ) i_acq (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .mode_chg (mode_chg),
    .hit      (hit),
    .seeded   (seeded),
    .drop     (drop),
    .in_sync  (in_sync),
    .acquire  (acquire)
  );

  prbs_err_window #(
    .WIN_LEN   (WIN_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) i_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (acquire || mode_chg),
    .chk_beat (chk_beat),
    .miss     (!hit),
    .drop     (drop)
  );

  assign bit_ready_o = ready_q;
  assign sync_o      = in_sync;
  assign err_o       = err_q;

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready_o |=> bit_ready_o); // R1

  AST_ERR_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(sync_o)); // R6

  AST_GAP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid_i && !mode_chg) |=> ($stable(sync_o) && !err_o)); // R9

endmodule

// File: tb/test_prbs_sync_mon.sv
`timescale 1ns/1ps
module test_prbs_sync_mon;

  logic clk = 1'b0;
  logic rst_n;
  logic line_mode_i, bit_valid_i, bit_data_i;
  logic bit_ready_o, sync_o, err_o;

  always #5 clk = ~clk;

  prbs_sync_mon i_prbs_sync_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_mode_i (line_mode_i),
    .bit_valid_i (bit_valid_i),
    .bit_data_i  (bit_data_i),
    .bit_ready_o (bit_ready_o),
    .sync_o      (sync_o),
    .err_o       (err_o)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  string tag = "R1";

  // Expected-behaviour model state
  bit        exp_sync, exp_err, exp_ready, m_mode;
  bit [19:0] mh;
  int        m_run, m_bits, m_errs;
  // Stimulus pattern state
  bit [19:0] gh;

  task automatic chk(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit tx_next(bit md);
    bit nb, ob;
    if (md == 1'b0) begin
      nb = gh[14] ^ gh[13];
      ob = nb;
    end else begin
      nb = gh[19] ^ gh[16];
      ob = nb | (gh[13:0] == 14'd0);
    end
    gh = {gh[18:0], nb};
    return ob;
  endfunction

  function automatic bit [19:0] back_t1(bit [19:0] s);
    return {s[0] ^ s[17], s[19:1]};
  endfunction

  task automatic model_step(bit md, bit v_in, bit rx);
    bit chg, raw, pred, nz, hit, v;
    v   = v_in && exp_ready;
    chg = (md != m_mode);
    m_mode = md;
    exp_ready = 1'b1;
    exp_err = 1'b0;
    if (md == 1'b0) begin
      raw = mh[14] ^ mh[13]; pred = raw; nz = |mh[14:0];
    end else begin
      raw = mh[19] ^ mh[16]; pred = raw | (mh[13:0] == 14'd0); nz = |mh;
    end
    hit = (rx == pred);
    if (chg) begin
      exp_sync = 1'b0; m_run = 0; m_bits = 0; m_errs = 0;
      if (v) mh = {mh[18:0], rx};
    end else if (v) begin
      if (!exp_sync) begin
        mh = {mh[18:0], rx};
        if (hit && nz) begin
          if (m_run == 31) begin
            exp_sync = 1'b1; m_run = 0; m_bits = 0; m_errs = 0;
          end else m_run++;
        end else m_run = 0;
      end else begin
        mh = {mh[18:0], raw};
        if (!hit) begin
          exp_err = 1'b1;
          if (m_errs == 10) begin
            exp_sync = 1'b0; m_run = 0; m_bits = 0; m_errs = 0;
          end else m_errs++;
        end
        if (exp_sync) begin
          if (m_bits == 999) begin m_bits = 0; m_errs = 0; end
          else m_bits++;
        end
      end
    end
  endtask

  task automatic drive(bit md, bit v, bit d);
    line_mode_i = md; bit_valid_i = v; bit_data_i = d;
    @(posedge clk);
    model_step(md, v, d);
    @(negedge clk);
    chk("sync_o", sync_o, exp_sync);
    chk("err_o", err_o, exp_err);
    chk("bit_ready_o", bit_ready_o, exp_ready);
  endtask

  task automatic send(bit md, bit v, bit flip);
    bit d;
    if (v) d = tx_next(md) ^ flip;
    else   d = 1'($urandom);
    drive(md, v, d);
  endtask

  task automatic acquire(bit md, int max_beats);
    for (int i = 0; i < max_beats && !exp_sync; i++) send(md, 1'b1, 1'b0);
    chk("sync acquired", sync_o, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_sync = 0; exp_err = 0; exp_ready = 0; m_mode = 0;
    mh = '0; m_run = 0; m_bits = 0; m_errs = 0;
    rst_n = 1'b0; line_mode_i = 0; bit_valid_i = 0; bit_data_i = 0;

    // R1: reset state and ready behaviour
    tag = "R1";
    repeat (4) @(negedge clk);
    chk("sync_o in reset", sync_o, 1'b0);
    chk("err_o in reset", err_o, 1'b0);
    chk("bit_ready_o in reset", bit_ready_o, 1'b0);
    rst_n = 1'b1;
    drive(0, 0, 0);
    drive(0, 0, 0);
    chk("bit_ready_o after reset", bit_ready_o, 1'b1);

    // R2 R3: clean E1 acquisition
    tag = "R2 R3";
    gh = 20'h0ACE1;
    acquire(0, 200);

    // R9: gaps in a clean E1 stream keep sync and raise no errors
    tag = "R9";
    for (int i = 0; i < 300; i++) send(0, ($urandom % 4) != 0, 1'b0);
    chk("sync through gaps", sync_o, 1'b1);

    // R8: short mode flip drops sync
    tag = "R8";
    drive(1, 0, 0);
    drive(0, 0, 0);
    chk("sync after mode flip", sync_o, 1'b0);

    // R6 R7: error window at block boundaries
    tag = "R6 R7";
    acquire(0, 200);
    for (int b = 0; b < 1000; b++) send(0, 1'b1, (b >= 200 && b < 210));
    chk("ten errors tolerated", sync_o, 1'b1);
    for (int b = 0; b < 11; b++) begin
      send(0, 1'b1, 1'b1);
      if (b == 9)  chk("still synced at tenth error", sync_o, 1'b1);
      if (b == 10) chk("eleventh error drops", sync_o, 1'b0);
    end
    acquire(0, 200);

    // R4 R8: switch to T1/J1 stream that passes through forced ones while synced
    tag = "R4 R8";
    gh = 20'h00001;
    for (int i = 0; i < 300; i++) gh = back_t1(gh);
    send(1, 1'b1, 1'b0);
    chk("sync cleared by mode change", sync_o, 1'b0);
    for (int i = 0; i < 599; i++) send(1, 1'b1, 1'b0);
    chk("T1 pattern in sync", sync_o, 1'b1);

    // R5: all-zero E1 stream never gives sync
    tag = "R5";
    for (int i = 0; i < 200; i++) drive(0, 1'b1, 1'b0);
    chk("zero stream no sync", sync_o, 1'b0);

    // R7 R9: random gaps, errors and rare mode changes
    tag = "R7 R9";
    gh = 20'h0BEEF;
    acquire(0, 200);
    begin
      bit md;
      md = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 1500) == 0) md = ~md;
        send(md, ($urandom % 4) != 0, ($urandom % 64) == 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule